// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that sits on a simple 32-bit register bus (word address, write strobe, write data, combinational read data). Software programs a coarse reload count and a clock divider, turns the timer on, and must then keep writing a fixed restart code. If no restart arrives before the down-counter runs out, the block latches an expiry flag. It can then raise a level interrupt, emit one reset pulse of programmable length, or both.

Stray writes must not upset the timer. Each write to the output/enable register or to the counter register is accepted only if it carries its own key pattern in a fixed field. A restart is honoured only when the written word equals the restart code exactly. The counter is loaded in coarse steps: the 12-bit reload field is multiplied by 2^STEP_SHIFT prescaled ticks (4096 by default).

Top module: `kwdt_top`

## Requirements
- R1: After reset every register reads zero, and `irq_o` and `rst_o` are low.
- R2: A write to byte offset 0x0 (mode) is accepted only when bits [23:12] equal 0xABC. Otherwise the mode register keeps its value. Accepted fields are: bit 0 run enable, bit 1 reset-output enable, bit 2 interrupt enable, bits [5:4] pulse length code.
- R3: A write to offset 0x4 (counter control) is accepted only when bits [23:14] equal 0x248, which is the value 0x00920000 in the word. Otherwise it is ignored. Accepted fields are: bits [13:2] reload value, bits [1:0] divider select.
- R4: Reads return the stored fields at their write positions, with key bits reading zero. Offset 0x8 (restart) reads zero. Offset 0xC (status) returns the expiry flag in bit 0.
- R5: Divider select 0, 1, 2 and 3 divides the clock by 2^P0, 2^P1, 2^P2 and 2^P3 (8, 64, 512 and 4096 by default). Expiry occurs exactly reload × 2^STEP_SHIFT × divider cycles after the edge that loads the counter.
- R6: Writing exactly 0x00001999 to offset 0x8 reloads the counter and restarts the divider. Any other value written there has no effect.
- R7: On expiry, status bit 0 sets and holds until a restart or a disable. The counter does not wrap.
- R8: `irq_o` is high exactly while the status flag and the interrupt enable are both set.
- R9: If the reset-output enable is set at expiry, `rst_o` gives one pulse of 2, 4, 8 or 16 cycles for length codes 0, 1, 2 and 3. The pulse starts on the same edge as the status flag.
- R10: A keyed mode write with bit 0 clear stops the counter and clears the status flag. No expiry follows.
- R11: A keyed mode write that turns the enable on from off loads the counter, so timing starts from that write.
- R12: A reload value of zero expires on the first prescaled tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address, bits [3:2] select the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Level interrupt on expiry |
| rst_o | output | 1 | Reset pulse on expiry |

## Verification
The bench builds the block with STEP_SHIFT = 2 and divider exponents 1, 2, 3 and 4. The coarse step is therefore 4 ticks and the dividers are 2, 4, 8 and 16, so each expiry falls within a few dozen cycles. With these values every divider select, every pulse length, zero reload and the ignored-restart case fit in one short run. Each expiry is checked at its exact cycle, one cycle before and on the expected edge, which exposes any off-by-one in the divider or in the counter load.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  // Register select, taken from byte address bits [3:2]
  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_CTL  = 2'd1;
  localparam logic [1:0] SEL_KICK = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  localparam logic [11:0] MODE_KEY  = 12'hABC;   // wdata[23:12]
  localparam logic [9:0]  CTL_KEY   = 10'h248;   // wdata[23:14]
  localparam logic [31:0] KICK_CODE = 32'h0000_1999;

  typedef struct packed {
    logic [1:0] plen;
    logic       irq_en;
    logic       rst_en;
    logic       run;
  } mode_t;

  function automatic logic [4:0] pulse_cycles(input logic [1:0] code);
    return 5'd2 << code;
  endfunction

endpackage

// File: rtl/kwdt_prescale.sv
module kwdt_prescale #(
  parameter int unsigned P0 = 3,
  parameter int unsigned P1 = 6,
  parameter int unsigned P2 = 9,
  parameter int unsigned P3 = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clr,
  input  logic [1:0] div_sel,
  output logic       tick
);
  localparam int unsigned M01   = (P0 > P1) ? P0 : P1;
  localparam int unsigned M23   = (P2 > P3) ? P2 : P3;
  localparam int unsigned PMAX  = (M01 > M23) ? M01 : M23;
  localparam int unsigned PRE_W = (PMAX < 1) ? 1 : PMAX;

  logic [PRE_W-1:0] lim [4];
  logic [PRE_W-1:0] pre_q, pre_d;

  for (genvar g = 0; g < 4; g++) begin : g_lim
    localparam int unsigned LG = (g == 0) ? P0 : (g == 1) ? P1 : (g == 2) ? P2 : P3;
    assign lim[g] = PRE_W'((64'd1 << LG) - 64'd1);
  end

  assign tick = run && (pre_q == lim[div_sel]);

  always_comb begin
    pre_d = pre_q;
    if (!run || clr || tick) pre_d = '0;
    else                     pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  a_r5_wrap_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pre_q == '0));

endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned RELOAD_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                status_i,
  output mode_t               mode_o,
  output logic [RELOAD_W-1:0] reload_o,
  output logic [1:0]          div_sel_o,
  output logic                load_o,
  output logic                dis_o
);
  logic [1:0] rsel;
  logic       mode_ok, ctl_ok, kick_ok;
  mode_t      mode_q, mode_d;
  logic [RELOAD_W-1:0] reload_q, reload_d;
  logic [1:0] sel_q, sel_d;

  assign rsel    = bus_addr[3:2];
  assign mode_ok = bus_we && (rsel == SEL_MODE) && (bus_wdata[23:12] == MODE_KEY);
  assign ctl_ok  = bus_we && (rsel == SEL_CTL)  && (bus_wdata[23:14] == CTL_KEY);
  assign kick_ok = bus_we && (rsel == SEL_KICK) && (bus_wdata == KICK_CODE);

  always_comb begin
    mode_d   = mode_q;
    reload_d = reload_q;
    sel_d    = sel_q;
    if (mode_ok) begin
      mode_d.run    = bus_wdata[0];
      mode_d.rst_en = bus_wdata[1];
      mode_d.irq_en = bus_wdata[2];
      mode_d.plen   = bus_wdata[5:4];
    end
    if (ctl_ok) begin
      reload_d = bus_wdata[2 +: RELOAD_W];
      sel_d    = bus_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      reload_q <= '0;
      sel_q    <= '0;
    end else begin
      mode_q   <= mode_d;
      reload_q <= reload_d;
      sel_q    <= sel_d;
    end
  end

  assign load_o    = kick_ok || (mode_ok && bus_wdata[0] && !mode_q.run);
  assign dis_o     = mode_ok && !bus_wdata[0];
  assign mode_o    = mode_q;
  assign reload_o  = reload_q;
  assign div_sel_o = sel_q;

  always_comb begin
    bus_rdata = '0;
    unique case (rsel)
      SEL_MODE: bus_rdata = {26'd0, mode_q.plen, 1'b0, mode_q.irq_en, mode_q.rst_en, mode_q.run};
      SEL_CTL:  bus_rdata = {{(30 - RELOAD_W){1'b0}}, reload_q, sel_q};
      SEL_KICK: bus_rdata = '0;
      SEL_STAT: bus_rdata = {31'd0, status_i};
      default:  bus_rdata = '0;
    endcase
  end

  // R2: an unkeyed mode write leaves the mode register untouched
  a_r2_mode_key: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && rsel == SEL_MODE && bus_wdata[23:12] != MODE_KEY) |=> $stable(mode_q));

  // R3: an unkeyed counter-control write leaves reload and divider untouched
  a_r3_ctl_key: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && rsel == SEL_CTL && bus_wdata[23:14] != CTL_KEY) |=> ($stable(reload_q) && $stable(sel_q)));

  // R6: a wrong restart value never produces a load
  a_r6_bad_kick: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && rsel == SEL_KICK && bus_wdata != KICK_CODE) |-> !load_o);

endmodule

// File: rtl/kwdt_core.sv
module kwdt_core
  import kwdt_pkg::*;
#(
  parameter int unsigned RELOAD_W   = 12,
  parameter int unsigned STEP_SHIFT = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                rst_en,
  input  logic                irq_en,
  input  logic [1:0]          plen,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                tick,
  input  logic                load,
  input  logic                dis,
  output logic                status_o,
  output logic                irq_o,
  output logic                rst_o
);
  localparam int unsigned CNT_W = RELOAD_W + STEP_SHIFT;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             stat_q, stat_d;
  logic [4:0]       pls_q, pls_d;
  logic             expire;

  assign expire = tick && !stat_q && !load && !dis && (cnt_q <= CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load)                                 cnt_d = {reload, {STEP_SHIFT{1'b0}}};
    else if (tick && !stat_q && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_comb begin
    stat_d = stat_q;
    if (load || dis) stat_d = 1'b0;
    else if (expire) stat_d = 1'b1;
  end

  always_comb begin
    pls_d = pls_q;
    if (expire && rst_en)  pls_d = pulse_cycles(plen);
    else if (pls_q != '0)  pls_d = pls_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stat_q <= 1'b0;
      pls_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      stat_q <= stat_d;
      pls_q  <= pls_d;
    end
  end

  assign status_o = stat_q;
  assign irq_o    = stat_q && irq_en;
  assign rst_o    = (pls_q != '0);

  // R7: the expiry flag holds until a restart or a disable
  a_r7_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !load && !dis) |=> stat_q);

  // R9: a reset pulse begins only together with a fresh expiry
  a_r9_pulse_at_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_o) |-> $rose(stat_q));

  // R10: while stopped and not reloaded, the counter does not move
  a_r10_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned RELOAD_W   = 12,
  parameter int unsigned STEP_SHIFT = 12,
  parameter int unsigned P0         = 3,
  parameter int unsigned P1         = 6,
  parameter int unsigned P2         = 9,
  parameter int unsigned P3         = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              rst_o
);
  mode_t               mode;
  logic [RELOAD_W-1:0] reload;
  logic [1:0]          div_sel;
  logic                load, dis, tick, status;

  kwdt_regs #(.ADDR_W(ADDR_W), .RELOAD_W(RELOAD_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .status_i(status), .mode_o(mode), .reload_o(reload), .div_sel_o(div_sel),
    .load_o(load), .dis_o(dis)
  );

  kwdt_prescale #(.P0(P0), .P1(P1), .P2(P2), .P3(P3)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(mode.run), .clr(load), .div_sel(div_sel), .tick(tick)
  );

  kwdt_core #(.RELOAD_W(RELOAD_W), .STEP_SHIFT(STEP_SHIFT)) u_core (
    .clk(clk), .rst_n(rst_n),
    .run(mode.run), .rst_en(mode.rst_en), .irq_en(mode.irq_en), .plen(mode.plen),
    .reload(reload), .tick(tick), .load(load), .dis(dis),
    .status_o(status), .irq_o(irq_o), .rst_o(rst_o)
  );

  // R8: the interrupt never shows while the flag is clear
  a_r8_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    !status |-> !irq_o);

endmodule

// File: tb/kwdt_top_tb_top.sv
module kwdt_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int STEP = 4;   // 2^STEP_SHIFT

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o, rst_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kwdt_top #(.STEP_SHIFT(2), .P0(1), .P1(2), .P2(3), .P3(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .rst_o(rst_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] ctl_word(input int rl, input int sel);
    return 32'h0092_0000 | (32'(rl) << 2) | 32'(sel);
  endfunction

  function automatic logic [31:0] mode_word(input bit run, input bit rsten, input bit irqen, input int len);
    return 32'h00AB_C000 | (32'(len) << 4) | {29'd0, irqen, rsten, run};
  endfunction

  task automatic stop_timer();
    wr(4'h0, mode_word(0, 0, 0, 0));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(4'(a * 4), d);
      chk("R1 reset readback", d, 32'h0);
    end
    chk("R1 irq after reset", {31'd0, irq_o}, 32'h0);
    chk("R1 rst after reset", {31'd0, rst_o}, 32'h0);
  endtask

  task automatic t_keys();
    logic [31:0] d;
    wr(4'h0, 32'h00AB_B007);
    rd(4'h0, d); chk("R2 bad mode key ignored", d, 32'h0);
    wr(4'h4, 32'h0093_0016);
    rd(4'h4, d); chk("R3 bad ctl key ignored", d, 32'h0);
    wr(4'h4, ctl_word(5, 2));
    rd(4'h4, d); chk("R3 R4 ctl accepted, key reads zero", d, 32'h16);
    wr(4'h0, mode_word(0, 1, 1, 3));
    rd(4'h0, d); chk("R2 R4 mode accepted, key reads zero", d, 32'h36);
    wr(4'h8, 32'h1999);
    rd(4'h8, d); chk("R4 restart reads zero", d, 32'h0);
    stop_timer();
  endtask

  // R5 R11: expiry lands on the exact edge after the enabling write
  task automatic t_timing(input int rl, input int sel);
    logic [31:0] d;
    int t;
    t = rl * STEP * (2 << sel);
    wr(4'h4, ctl_word(rl, sel));
    wr(4'h0, mode_word(1, 0, 1, 0));
    cyc(t - 1);
    rd(4'hC, d); chk("R5 R11 no expiry one cycle early", d, 32'h0);
    chk("R8 irq low before expiry", {31'd0, irq_o}, 32'h0);
    cyc(1);
    rd(4'hC, d); chk("R5 R11 expiry on time", d, 32'h1);
    chk("R8 irq high on expiry", {31'd0, irq_o}, 32'h1);
    stop_timer();
  endtask

  task automatic t_kick();
    logic [31:0] d;
    wr(4'h4, ctl_word(2, 1));          // 32 cycles
    wr(4'h0, mode_word(1, 0, 1, 0));
    cyc(10);
    wr(4'h8, 32'h0000_1998);           // ignored
    cyc(20);
    rd(4'hC, d); chk("R6 bad restart ignored, early", d, 32'h0);
    cyc(1);
    rd(4'hC, d); chk("R6 bad restart ignored, expiry kept", d, 32'h1);
    wr(4'h8, 32'h0000_1999);
    rd(4'hC, d); chk("R7 restart clears status", d, 32'h0);
    cyc(31);
    rd(4'hC, d); chk("R6 restart reloads, early", d, 32'h0);
    cyc(1);
    rd(4'hC, d); chk("R6 restart reloads, expiry", d, 32'h1);
    cyc(40);
    rd(4'hC, d); chk("R7 status held", d, 32'h1);
    stop_timer();
    rd(4'hC, d); chk("R10 disable clears status", d, 32'h0);
  endtask

  task automatic t_irq_mask();
    logic [31:0] d;
    wr(4'h4, ctl_word(0, 2));          // R12: 8 cycles
    wr(4'h0, mode_word(1, 0, 0, 0));
    cyc(7);
    rd(4'hC, d); chk("R12 zero reload, early", d, 32'h0);
    cyc(1);
    rd(4'hC, d); chk("R12 zero reload expires after one tick", d, 32'h1);
    chk("R8 irq masked", {31'd0, irq_o}, 32'h0);
    wr(4'h0, mode_word(1, 0, 1, 0));
    chk("R8 irq follows enable", {31'd0, irq_o}, 32'h1);
    stop_timer();
  endtask

  task automatic t_pulse();
    int hi, rises;
    logic prev;
    wr(4'h4, ctl_word(1, 0));          // 8 cycles
    for (int len = 0; len < 4; len++) begin
      wr(4'h0, mode_word(1, 1, 0, len));
      cyc(7);
      chk("R9 no pulse before expiry", {31'd0, rst_o}, 32'h0);
      hi = 0; rises = 0; prev = 1'b0;
      for (int i = 0; i < 40; i++) begin
        cyc(1);
        if (rst_o) hi++;
        if (rst_o && !prev) rises++;
        prev = rst_o;
      end
      chk("R9 pulse length", 32'(hi), 32'(2 << len));
      chk("R9 single pulse", 32'(rises), 32'd1);
      stop_timer();
    end
  endtask

  task automatic t_disable();
    logic [31:0] d;
    wr(4'h4, ctl_word(2, 1));          // 32 cycles
    wr(4'h0, mode_word(1, 1, 1, 0));
    cyc(10);
    stop_timer();
    cyc(60);
    rd(4'hC, d); chk("R10 no expiry after disable", d, 32'h0);
    chk("R10 no reset pulse after disable", {31'd0, rst_o}, 32'h0);
  endtask

  initial begin
    bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_keys();
    t_timing(3, 0);
    t_timing(2, 1);
    t_timing(1, 2);
    t_timing(1, 3);
    t_kick();
    t_irq_mask();
    t_pulse();
    t_disable();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule